// File: doc/BRIEF.md
# Activity Performance Counter Unit

This unit keeps two clock counters under command control. One advances on every clock while counting is enabled. The other advances only on enabled clocks in which at least one processor of an array reports itself busy. The busy condition is the OR of a per-processor activity vector.

Software drives the unit through a command stream with four operations: init, start, stop and read. A read carries a base address. The unit captures both counts in the cycle it accepts the read. It then sends two words out through a memory write request port. The total count goes to the base address, and the active count goes to the base address plus one element stride.

Both the command input and the write output use valid/ready handshakes. On the command side, `cmd_ready` is low for the whole write-out, and commands offered during that time are not taken. On the write side, a word is transferred on any clock edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold steady. The sink may keep `wr_ready` low for any number of cycles.

Top module: `perf_activity_counter`

## Requirements
- R1: At reset both counts are zero and counting is stopped. No write is pending, `busy` is low and `cmd_ready` is high.
- R2: While counting, the total count rises by one on each clock edge that accepts no command other than a read.
- R3: While counting, the active count rises by one on such an edge only when at least one bit of `proc_active` is set. It never changes on an edge where the total count stays the same.
- R4: A start command (`cmd_op` = 1) clears both counts and enables counting. The first increment falls on the edge after the start is accepted.
- R5: A stop command (`cmd_op` = 2) disables counting. No increment happens on the edge that accepts it, and both counts keep their values until the next clear.
- R6: An init command (`cmd_op` = 0) clears both counts and leaves counting disabled.
- R7: A read command (`cmd_op` = 3) captures the counts as they were before the accepting edge. From the next cycle, the unit presents the total count at `cmd_addr` and then the active count at `cmd_addr` + 4. Counting goes on during the write-out.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged. The second word appears only after the first has been transferred.
- R9: `busy` is high and `cmd_ready` is low from the cycle after a read is accepted until the second word is transferred. A command offered in that window has no effect.
- R10: The counts are `CNT_W` bits wide and wrap to zero after their largest value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The unit can take a command |
| cmd_op | input | 2 | 0 init, 1 start, 2 stop, 3 read |
| cmd_addr | input | ADDR_W | Base address of a read |
| proc_active | input | NPROC | Per-processor busy flags |
| wr_valid | output | 1 | Write request is presented |
| wr_ready | input | 1 | Sink takes the write request |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | CNT_W | Write data (a count) |
| busy | output | 1 | A read write-out is in progress |

## Verification
The assertions assume that `rst_n` is held for at least one edge, and that `cmd_op` and `cmd_addr` are stable whenever `cmd_valid` is high. They make no assumption about how long `wr_ready` stays low. The stimulus changes inputs only between edges. It holds `wr_ready` low for random stretches and offers commands while the unit is busy, to show that these commands are not taken. It also keeps a narrow counter width long enough to reach the wrap point.

// File: rtl/perf_pkg.sv
package perf_pkg;
  typedef enum logic [1:0] {
    OP_INIT  = 2'd0,
    OP_START = 2'd1,
    OP_STOP  = 2'd2,
    OP_READ  = 2'd3
  } perf_op_e;

  typedef enum logic [1:0] {
    WO_IDLE  = 2'd0,
    WO_TOTAL = 2'd1,
    WO_ACTV  = 2'd2
  } wo_state_e;

  localparam int unsigned NUM_CNT = 2;
endpackage

// File: rtl/perf_cmd_decode.sv
module perf_cmd_decode
  import perf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       busy,
  output logic       cmd_ready,
  output logic       cnt_clear,
  output logic       cnt_step,
  output logic       snap
);
  logic     run_q;
  logic     accept;
  perf_op_e op;

  assign op        = perf_op_e'(cmd_op);
  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign cnt_clear = accept && (op == OP_INIT || op == OP_START);
  assign snap      = accept && (op == OP_READ);
  assign cnt_step  = run_q && !(accept && op != OP_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (accept) begin
      unique case (op)
        OP_START:         run_q <= 1'b1;
        OP_INIT, OP_STOP: run_q <= 1'b0;
        default:          run_q <= run_q;
      endcase
    end
  end

  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_STOP) |=> !cnt_step); // R5
  AST_INIT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_INIT) |=> !cnt_step); // R6
endmodule

// File: rtl/perf_counter.sv
module perf_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             enable,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n || clear) count <= '0;
    else if (enable)     count <= count + ONE;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !enable) |=> $stable(count)); // R5
endmodule

// File: rtl/perf_writeout.sv
module perf_writeout
  import perf_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned ELEM_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snap,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  total_in,
  input  logic [CNT_W-1:0]  active_in,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [CNT_W-1:0]  wr_data,
  output logic              busy
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(ELEM_BYTES);

  wo_state_e         st_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  tot_q;
  logic [CNT_W-1:0]  act_q;
  logic              xfer;

  assign xfer     = wr_valid && wr_ready;
  assign wr_valid = (st_q != WO_IDLE);
  assign busy     = (st_q != WO_IDLE);
  assign wr_addr  = (st_q == WO_ACTV) ? base_q + STRIDE : base_q;
  assign wr_data  = (st_q == WO_ACTV) ? act_q : tot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= WO_IDLE;
    end else begin
      unique case (st_q)
        WO_IDLE:  if (snap) st_q <= WO_TOTAL;
        WO_TOTAL: if (xfer) st_q <= WO_ACTV;
        WO_ACTV:  if (xfer) st_q <= WO_IDLE;
        default:  st_q <= WO_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      tot_q  <= '0;
      act_q  <= '0;
    end else if (snap && st_q == WO_IDLE) begin
      base_q <= base_addr;
      tot_q  <= total_in;
      act_q  <= active_in;
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R8
  AST_SECOND_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && st_q == WO_TOTAL) |=> (wr_valid && wr_addr == $past(wr_addr) + STRIDE)); // R7
  AST_SNAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    snap |-> !busy); // R9
endmodule

// File: rtl/perf_activity_counter.sv
module perf_activity_counter
  import perf_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned NPROC      = 8,
  parameter int unsigned ELEM_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [NPROC-1:0]  proc_active,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [CNT_W-1:0]  wr_data,
  output logic              busy
);
  logic                cnt_clear;
  logic                cnt_step;
  logic                snap;
  logic                any_active;
  logic [NUM_CNT-1:0]  en_vec;
  logic [CNT_W-1:0]    cnt_val [NUM_CNT];

  assign any_active = |proc_active;
  assign en_vec[0]  = cnt_step;
  assign en_vec[1]  = cnt_step && any_active;

  perf_cmd_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .cmd_ready (cmd_ready),
    .cnt_clear (cnt_clear),
    .cnt_step  (cnt_step),
    .snap      (snap)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    perf_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (cnt_clear),
      .enable (en_vec[g]),
      .count  (cnt_val[g])
    );
  end

  perf_writeout #(
    .CNT_W      (CNT_W),
    .ADDR_W     (ADDR_W),
    .ELEM_BYTES (ELEM_BYTES)
  ) u_wo (
    .clk       (clk),
    .rst_n     (rst_n),
    .snap      (snap),
    .base_addr (cmd_addr),
    .total_in  (cnt_val[0]),
    .active_in (cnt_val[1]),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .busy      (busy)
  );

  AST_ACTIVE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_val[1]) |-> !$stable(cnt_val[0])); // R3
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid); // R1
endmodule

// File: tb/perf_activity_counter_tb.sv
module perf_activity_counter_tb;
  localparam int CW = 16;
  localparam int AW = 32;
  localparam int NP = 8;
  localparam longint MASK = (64'd1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [NP-1:0] proc_active = '0;
  logic wr_valid;
  logic wr_ready = 1'b0;
  logic [AW-1:0] wr_addr;
  logic [CW-1:0] wr_data;
  logic busy;

  always #10 clk = ~clk;

  perf_activity_counter #(.CNT_W(CW), .ADDR_W(AW), .NPROC(NP), .ELEM_BYTES(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .proc_active(proc_active),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy)
  );

  int checks = 0;
  int failures = 0;
  string cur_req = "R7";

  longint m_tot = 0;
  longint m_act = 0;
  bit m_run = 0;
  longint qa[$];
  longint qd[$];

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit v, logic [1:0] op, logic [AW-1:0] ad,
                      logic [NP-1:0] act, bit rdy);
    bit pend;
    cmd_valid = v; cmd_op = op; cmd_addr = ad; proc_active = act; wr_ready = rdy;
    #1;
    pend = (qa.size() != 0);
    chk(busy == pend, "R9 busy", busy, pend);
    chk(cmd_ready == !pend, "R9 cmd_ready", cmd_ready, !pend);
    chk(wr_valid == pend, "R7 wr_valid", wr_valid, pend);
    if (pend && wr_valid) begin
      chk(wr_addr == qa[0][AW-1:0], "R7 wr_addr", wr_addr, qa[0]);
      chk(wr_data == qd[0][CW-1:0], {cur_req, " wr_data"}, wr_data, qd[0]);
    end
    if (pend && rdy) begin
      void'(qa.pop_front());
      void'(qd.pop_front());
    end
    if (v && !pend) begin
      case (op)
        2'd0: begin m_tot = 0; m_act = 0; m_run = 0; end
        2'd1: begin m_tot = 0; m_act = 0; m_run = 1; end
        2'd2: m_run = 0;
        default: begin
          qa.push_back(ad);        qd.push_back(m_tot);
          qa.push_back(ad + 4);    qd.push_back(m_act);
          if (m_run) begin
            m_tot = (m_tot + 1) & MASK;
            if (|act) m_act = (m_act + 1) & MASK;
          end
        end
      endcase
    end else if (m_run) begin
      m_tot = (m_tot + 1) & MASK;
      if (|act) m_act = (m_act + 1) & MASK;
    end
    @(negedge clk);
  endtask

  task automatic idle(int n, logic [NP-1:0] act);
    for (int i = 0; i < n; i++) step(0, 2'd0, '0, act, 1'b1);
  endtask

  task automatic drain(bit bp);
    while (qa.size() != 0) step(0, 2'd0, '0, NP'($urandom), bp ? 1'($urandom) : 1'b1);
    step(0, 2'd0, '0, '0, 1'b1);
  endtask

  task automatic rd(logic [AW-1:0] ad, logic [NP-1:0] act, bit bp);
    step(1, 2'd3, ad, act, 1'b1);
    drain(bp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(busy == 0, "R1 busy", busy, 0);
    chk(cmd_ready == 1, "R1 cmd_ready", cmd_ready, 1);
    chk(wr_valid == 0, "R1 wr_valid", wr_valid, 0);
    @(negedge clk);
    cur_req = "R1"; idle(5, '0); rd(32'h100, '0, 0);

    cur_req = "R2"; step(1, 2'd1, '0, '0, 1); idle(17, '0); rd(32'h200, '0, 0);

    cur_req = "R3";
    for (int i = 0; i < 40; i++) step(0, 2'd0, '0, (i % 3 == 0) ? NP'(1 << (i % NP)) : '0, 1);
    idle(10, '1);
    rd(32'h300, 8'h80, 0);

    cur_req = "R8";
    for (int i = 0; i < 6; i++) rd(32'h400 + 32'(i * 16), NP'($urandom), 1);

    cur_req = "R9";
    step(1, 2'd3, 32'h500, '0, 0);
    step(1, 2'd2, '0, '1, 0);
    step(1, 2'd0, '0, '1, 0);
    step(1, 2'd1, '0, '1, 1);
    step(1, 2'd3, 32'h9990, '1, 0);
    drain(0);
    idle(3, '1); rd(32'h540, '1, 0);

    cur_req = "R5"; step(1, 2'd2, '0, '1, 1); idle(20, '1);
    rd(32'h600, '1, 0); idle(5, '1); rd(32'h610, '1, 1);

    cur_req = "R4"; step(1, 2'd1, '0, '1, 1); rd(32'h700, '1, 0);
    idle(9, '1); rd(32'h710, 8'h01, 0);

    cur_req = "R6"; step(1, 2'd0, '0, '1, 1); idle(8, '1); rd(32'h800, '1, 0);

    cur_req = "R10"; step(1, 2'd1, '0, '1, 1);
    idle(65536 + 12, 8'h04);
    rd(32'h900, '1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule